// File: doc/BRIEF.md
# Low-Power Exit Wake Sequencer

This block is the control core of a power manager. It takes a processor subsystem into a low-power state and later brings it back to full operation. Software requests entry with a one-cycle pulse. The mode bits present at that moment are captured and govern the whole sleep episode:

- system-wide sleep or core-only sleep;
- whether the memory controller is also put into low power;
- deep or light core sleep;
- host or agent role.

While asleep, the sequencer watches a set of level-sensitive wake sources. No wake is accepted unless the wake-interrupt enable input is high. On a wake it records a sticky event flag for software.

After a system-wide sleep, units are restored in a fixed order. The memory controller comes back first, and only if it was put to sleep; the sequencer waits for its ready handshake. Next, every other unit is enabled and the core receives a one-cycle interrupt. The sequencer then waits until every unit and the core report ready. Finally it drops quiesce for one release cycle. On the following cycle it clears the sleep flag and grants held bus requests.

After a core-only sleep, the sequencer skips unit sequencing. It waits only for the core to report ready.

Top module: `lpx_wake_seq`

## Requirements
- R1: After reset the block is fully on: sleepEn=0, wakeEvent=0, quiesce=0, memEnable=1, unitEnable all ones, coreIrq=0, busGrant=1.
- R2: A sleepReq pulse while fully on enters sleep at the next edge. sleepEn becomes 1 and busGrant 0. In system mode, quiesce becomes 1 and unitEnable all zeros. sleepReq at any other time has no effect.
- R3: While wakeIrqEn is 0, no wake source leaves sleep and wakeEvent stays 0.
- R4: In system mode the wake sources are the core timer request, the interrupt request, busReqPending when host mode was captured, and pmNext differing from pmCur when agent mode was captured. busReqPending is ignored in agent mode, and in core-only mode.
- R5: In core-only mode, quiesce stays 0 and units stay enabled. Light sleep wakes on the interrupt or the timer request. Deep sleep ignores the timer and wakes only on the interrupt. After the wake, coreReady alone leads to release.
- R6: If memory low power was captured, memEnable is 0 in sleep. It returns to 1 at the wake edge while units stay off. The sequencer holds there until memReady is 1. A memReady already high is accepted in the first such cycle.
- R7: If memory low power was not captured, memEnable stays 1 throughout and the memory step is skipped.
- R8: After memory, units are enabled and coreIrq is 1 for exactly one cycle. The wait for readiness follows.
- R9: In system mode, release requires every bit of unitReady and coreReady together. Partial readiness holds quiesce at 1 and busGrant at 0.
- R10: On release, quiesce falls one cycle before busGrant rises. sleepEn clears at the same edge at which busGrant rises.
- R11: wakeEvent is set on a wake and cleared only by evtClr. Sources active together, or staying active after the wake, produce one sequence and no second event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleepReq | input | 1 | Pulse requesting entry into low power |
| cfgSysMode | input | 1 | 1 = system-wide sleep, 0 = core-only (captured on entry) |
| cfgMemLp | input | 1 | Put memory into low power (captured on entry) |
| cfgDeepCore | input | 1 | 1 = deep core sleep, interrupt-only wake (captured on entry) |
| cfgHostMode | input | 1 | 1 = host role, 0 = agent role (captured on entry) |
| wakeIrqEn | input | 1 | Wake interrupt enable mask bit |
| evtClr | input | 1 | Software clear of the wake event flag |
| coreTbReq | input | 1 | Core time-base wake request |
| coreIrqReq | input | 1 | Interrupt request to the core |
| busReqPending | input | 1 | Outstanding internal-bus transaction requests |
| pmNext | input | PSTATE_W | Requested device power state (agent role) |
| pmCur | input | PSTATE_W | Current device power state (agent role) |
| memReady | input | 1 | Memory controller back in auto-refresh |
| unitReady | input | NUM_UNITS | Per-unit ready |
| coreReady | input | 1 | Core ready |
| sleepEn | output | 1 | Sleep-enable flag |
| wakeEvent | output | 1 | Sticky wake event flag |
| quiesce | output | 1 | System quiesce indication |
| memEnable | output | 1 | Memory controller clock/refresh enable |
| unitEnable | output | NUM_UNITS | Per-unit enable |
| coreIrq | output | 1 | One-cycle wake interrupt to the core |
| busGrant | output | 1 | Held bus requests may proceed |

## Verification
The hardest situation to reach is a wake in which several sources are already high and stay high through the rest of the sequence. In the same episode, memReady is also high before the memory step starts. This exercises both single-event capture and same-cycle ready acceptance. The stimulus raises the timer, interrupt and bus-request inputs together with memReady in the first cycle of sleep, and keeps them up through release. The bench then confirms one event, one memory cycle and a clean return to full-on. Mode capture at entry is also exercised: an agent-role episode presents a bus request that must be ignored.

// File: rtl/lpx_pkg.sv
package lpx_pkg;

  typedef enum logic [2:0] {
    ST_FULL_ON      = 3'd0,
    ST_SLEEP        = 3'd1,
    ST_MEM_RESTORE  = 3'd2,
    ST_UNITS_ENABLE = 3'd3,
    ST_WAIT_READY   = 3'd4,
    ST_RELEASE      = 3'd5
  } seqState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic latchCfg;   // capture mode bits at sleep entry
    logic setSleep;   // set sleep-enable flag
    logic clrSleep;   // clear sleep-enable flag
    logic setEvent;   // record a wake event
    logic quiesceOn;  // quiesce phase (system mode only)
    logic memOff;     // memory held in self-refresh phase
    logic unitsOff;   // units held disabled phase
    logic irqOn;      // wake interrupt to core
    logic grantOn;    // fully on, bus may be granted
  } seqStrobe_t;

endpackage

// File: rtl/lpx_wake_detect.sv
module lpx_wake_detect #(
  parameter int PSTATE_W = 2
) (
  input  logic                sysLat,
  input  logic                deepLat,
  input  logic                hostLat,
  input  logic                wakeIrqEn,
  input  logic                coreTbReq,
  input  logic                coreIrqReq,
  input  logic                busReqPending,
  input  logic [PSTATE_W-1:0] pmNext,
  input  logic [PSTATE_W-1:0] pmCur,
  output logic                wakeHit
);

  logic [PSTATE_W-1:0] pmDiff;
  logic                pmMismatch;
  logic                sysSrc;
  logic                coreSrc;

  // Per-bit compare of requested and current power state.
  for (genvar b = 0; b < PSTATE_W; b++) begin : g_pmcmp
    assign pmDiff[b] = pmNext[b] ^ pmCur[b];
  end

  assign pmMismatch = |pmDiff;

  always_comb begin
    sysSrc = coreTbReq | coreIrqReq;
    if (hostLat) sysSrc = sysSrc | busReqPending;
    else         sysSrc = sysSrc | pmMismatch;
  end

  // Core-only mode: deep sleep ignores the time base.
  assign coreSrc = coreIrqReq | (coreTbReq & ~deepLat);

  assign wakeHit = wakeIrqEn & (sysLat ? sysSrc : coreSrc);

endmodule

// File: rtl/lpx_seq_ctrl.sv
module lpx_seq_ctrl
  import lpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleepReq,
  input  logic       wakeHit,
  input  logic       memReady,
  input  logic       allReady,
  input  logic       sysLat,
  input  logic       memLpLat,
  output seqStrobe_t strobe
);

  seqState_e stateQ;
  seqState_e stateD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_FULL_ON;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_FULL_ON: begin
        strobe.grantOn = 1'b1;
        if (sleepReq) begin
          strobe.latchCfg = 1'b1;
          strobe.setSleep = 1'b1;
          stateD          = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        strobe.quiesceOn = 1'b1;
        strobe.memOff    = 1'b1;
        strobe.unitsOff  = 1'b1;
        if (wakeHit) begin
          strobe.setEvent = 1'b1;
          if (!sysLat)       stateD = ST_WAIT_READY;
          else if (memLpLat) stateD = ST_MEM_RESTORE;
          else               stateD = ST_UNITS_ENABLE;
        end
      end
      ST_MEM_RESTORE: begin
        strobe.quiesceOn = 1'b1;
        strobe.unitsOff  = 1'b1;
        if (memReady) stateD = ST_UNITS_ENABLE;
      end
      ST_UNITS_ENABLE: begin
        strobe.quiesceOn = 1'b1;
        strobe.irqOn     = 1'b1;
        stateD           = ST_WAIT_READY;
      end
      ST_WAIT_READY: begin
        strobe.quiesceOn = 1'b1;
        if (allReady) stateD = ST_RELEASE;
      end
      ST_RELEASE: begin
        strobe.clrSleep = 1'b1;
        stateD          = ST_FULL_ON;
      end
      default: stateD = ST_FULL_ON;
    endcase
  end

endmodule

// File: rtl/lpx_seq_dp.sv
module lpx_seq_dp
  import lpx_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seqStrobe_t           strobe,
  input  logic                 cfgSysMode,
  input  logic                 cfgMemLp,
  input  logic                 cfgDeepCore,
  input  logic                 cfgHostMode,
  input  logic                 evtClr,
  input  logic [NUM_UNITS-1:0] unitReady,
  input  logic                 coreReady,
  output logic                 sysLat,
  output logic                 memLpLat,
  output logic                 deepLat,
  output logic                 hostLat,
  output logic                 allReady,
  output logic                 sleepEn,
  output logic                 wakeEvent,
  output logic                 quiesce,
  output logic                 memEnable,
  output logic [NUM_UNITS-1:0] unitEnable,
  output logic                 coreIrq,
  output logic                 busGrant
);

  // Mode bits captured once per sleep episode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sysLat   <= 1'b0;
      memLpLat <= 1'b0;
      deepLat  <= 1'b0;
      hostLat  <= 1'b0;
    end else if (strobe.latchCfg) begin
      sysLat   <= cfgSysMode;
      memLpLat <= cfgMemLp;
      deepLat  <= cfgDeepCore;
      hostLat  <= cfgHostMode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sleepEn <= 1'b0;
    else if (strobe.setSleep) sleepEn <= 1'b1;
    else if (strobe.clrSleep) sleepEn <= 1'b0;
  end

  // Event flag: a new wake wins over a software clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wakeEvent <= 1'b0;
    else if (strobe.setEvent) wakeEvent <= 1'b1;
    else if (evtClr)          wakeEvent <= 1'b0;
  end

  assign allReady = sysLat ? ((&unitReady) & coreReady) : coreReady;

  assign quiesce    = strobe.quiesceOn & sysLat;
  assign memEnable  = ~(strobe.memOff & sysLat & memLpLat);
  assign unitEnable = {NUM_UNITS{~(strobe.unitsOff & sysLat)}};
  assign coreIrq    = strobe.irqOn;
  assign busGrant   = strobe.grantOn;

endmodule

// File: rtl/lpx_wake_seq.sv
module lpx_wake_seq
  import lpx_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int PSTATE_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleepReq,
  input  logic                 cfgSysMode,
  input  logic                 cfgMemLp,
  input  logic                 cfgDeepCore,
  input  logic                 cfgHostMode,
  input  logic                 wakeIrqEn,
  input  logic                 evtClr,
  input  logic                 coreTbReq,
  input  logic                 coreIrqReq,
  input  logic                 busReqPending,
  input  logic [PSTATE_W-1:0]  pmNext,
  input  logic [PSTATE_W-1:0]  pmCur,
  input  logic                 memReady,
  input  logic [NUM_UNITS-1:0] unitReady,
  input  logic                 coreReady,
  output logic                 sleepEn,
  output logic                 wakeEvent,
  output logic                 quiesce,
  output logic                 memEnable,
  output logic [NUM_UNITS-1:0] unitEnable,
  output logic                 coreIrq,
  output logic                 busGrant
);

  seqStrobe_t strobe;
  logic       sysLat;
  logic       memLpLat;
  logic       deepLat;
  logic       hostLat;
  logic       allReady;
  logic       wakeHit;

  lpx_wake_detect #(.PSTATE_W(PSTATE_W)) u_detect (
    .sysLat       (sysLat),
    .deepLat      (deepLat),
    .hostLat      (hostLat),
    .wakeIrqEn    (wakeIrqEn),
    .coreTbReq    (coreTbReq),
    .coreIrqReq   (coreIrqReq),
    .busReqPending(busReqPending),
    .pmNext       (pmNext),
    .pmCur        (pmCur),
    .wakeHit      (wakeHit)
  );

  lpx_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleepReq(sleepReq),
    .wakeHit (wakeHit),
    .memReady(memReady),
    .allReady(allReady),
    .sysLat  (sysLat),
    .memLpLat(memLpLat),
    .strobe  (strobe)
  );

  lpx_seq_dp #(.NUM_UNITS(NUM_UNITS)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .cfgSysMode (cfgSysMode),
    .cfgMemLp   (cfgMemLp),
    .cfgDeepCore(cfgDeepCore),
    .cfgHostMode(cfgHostMode),
    .evtClr     (evtClr),
    .unitReady  (unitReady),
    .coreReady  (coreReady),
    .sysLat     (sysLat),
    .memLpLat   (memLpLat),
    .deepLat    (deepLat),
    .hostLat    (hostLat),
    .allReady   (allReady),
    .sleepEn    (sleepEn),
    .wakeEvent  (wakeEvent),
    .quiesce    (quiesce),
    .memEnable  (memEnable),
    .unitEnable (unitEnable),
    .coreIrq    (coreIrq),
    .busGrant   (busGrant)
  );

endmodule

// File: rtl/lpx_wake_seq_chk.sv
module lpx_wake_seq_chk #(
  parameter int NUM_UNITS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sleepReq,
  input logic                 wakeIrqEn,
  input logic                 evtClr,
  input logic                 coreReady,
  input logic                 sleepEn,
  input logic                 wakeEvent,
  input logic                 quiesce,
  input logic                 memEnable,
  input logic [NUM_UNITS-1:0] unitEnable,
  input logic                 coreIrq,
  input logic                 busGrant
);

  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleepEn) |-> $past(sleepReq));

  assert_wake_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wakeEvent) |-> $past(wakeIrqEn));

  assert_mem_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (quiesce && (|unitEnable)) |-> memEnable);

  assert_irq_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    coreIrq |=> !coreIrq);

  assert_grant_after_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busGrant) |-> $past(coreReady, 2));

  assert_grant_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busGrant |-> (!quiesce && !sleepEn));

  assert_quiesce_lead_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busGrant) |-> !$past(quiesce));

  assert_event_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wakeEvent && !evtClr) |=> wakeEvent);

endmodule

bind lpx_wake_seq lpx_wake_seq_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (.*);

// File: tb/test_lpx_wake_seq.sv
module test_lpx_wake_seq;

  localparam int NU = 4;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleepReq = 0, cfgSysMode = 0, cfgMemLp = 0, cfgDeepCore = 0;
  logic          cfgHostMode = 0, wakeIrqEn = 0, evtClr = 0;
  logic          coreTbReq = 0, coreIrqReq = 0, busReqPending = 0;
  logic [PW-1:0] pmNext = '0, pmCur = '0;
  logic          memReady = 0, coreReady = 0;
  logic [NU-1:0] unitReady = '0;
  logic          sleepEn, wakeEvent, quiesce, memEnable, coreIrq, busGrant;
  logic [NU-1:0] unitEnable;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  lpx_wake_seq #(.NUM_UNITS(NU), .PSTATE_W(PW)) i_lpx_wake_seq (.*);

  typedef struct packed {
    logic sr, sys, mlp, dp, hst, ien, tb, irq, brq, pmx, mrd, urd, crd, clr;
    logic eq, em, eu, ec, eg, es, ee;
  } vec_t;

  localparam int NV = 33;
  //  inputs: sr sys mlp dp hst ien tb irq brq pmx mrd urd crd clr | expect: qui mem uni cir gnt sle evt
  localparam vec_t VECS [NV] = '{
    // A: system, memory low power, host (R2 R3 R6 R8 R9 R10 R11)
    '{1,1,1,0,1,1,0,0,0,0,0,0,0,0, 1,0,0,0,0,1,0},
    '{0,1,1,0,1,0,0,1,0,0,0,0,0,0, 1,0,0,0,0,1,0},
    '{0,1,1,0,1,1,0,1,0,0,0,0,0,0, 1,1,0,0,0,1,1},
    '{0,1,1,0,1,1,0,0,0,0,0,0,0,0, 1,1,0,0,0,1,1},
    '{0,1,1,0,1,1,0,0,0,0,1,0,0,0, 1,1,1,1,0,1,1},
    '{0,1,1,0,1,1,0,0,0,0,0,0,0,0, 1,1,1,0,0,1,1},
    '{1,1,1,0,1,1,0,0,0,0,0,1,0,0, 1,1,1,0,0,1,1},
    '{0,1,1,0,1,1,0,0,0,0,0,1,1,0, 0,1,1,0,0,1,1},
    '{0,1,1,0,1,1,0,0,0,0,0,0,0,0, 0,1,1,0,1,0,1},
    '{0,1,1,0,1,1,0,0,0,0,0,0,0,1, 0,1,1,0,1,0,0},
    // B: system, no memory low power, agent: bus request ignored, state mismatch wakes (R4 R7)
    '{1,1,0,0,0,1,0,0,0,0,0,0,0,0, 1,1,0,0,0,1,0},
    '{0,1,0,0,0,1,0,0,1,0,0,0,0,0, 1,1,0,0,0,1,0},
    '{0,1,0,0,0,1,0,0,0,1,0,0,0,0, 1,1,1,1,0,1,1},
    '{0,1,0,0,0,1,0,0,0,1,0,1,1,0, 1,1,1,0,0,1,1},
    '{0,1,0,0,0,1,0,0,0,0,0,1,1,0, 0,1,1,0,0,1,1},
    '{0,1,0,0,0,1,0,0,0,0,0,0,0,0, 0,1,1,0,1,0,1},
    // C: simultaneous sources held high, memReady already high (R4 R6 R11)
    '{1,1,1,0,1,1,0,0,0,0,0,0,0,1, 1,0,0,0,0,1,0},
    '{0,1,1,0,1,1,1,1,1,0,1,0,0,0, 1,1,0,0,0,1,1},
    '{0,1,1,0,1,1,1,1,1,0,1,0,0,0, 1,1,1,1,0,1,1},
    '{0,1,1,0,1,1,1,1,1,0,0,0,0,0, 1,1,1,0,0,1,1},
    '{0,1,1,0,1,1,1,1,1,0,0,1,1,1, 0,1,1,0,0,1,0},
    '{0,1,1,0,1,1,1,1,1,0,0,0,0,0, 0,1,1,0,1,0,0},
    // D: core-only deep sleep, timer ignored (R5)
    '{1,0,0,1,0,1,0,0,0,0,0,0,0,0, 0,1,1,0,0,1,0},
    '{0,0,0,1,0,1,1,0,0,0,0,0,0,0, 0,1,1,0,0,1,0},
    '{0,0,0,1,0,1,0,1,0,0,0,0,0,0, 0,1,1,0,0,1,1},
    '{0,0,0,1,0,1,0,0,0,0,0,1,0,0, 0,1,1,0,0,1,1},
    '{0,0,0,1,0,1,0,0,0,0,0,0,1,0, 0,1,1,0,0,1,1},
    '{0,0,0,1,0,1,0,0,0,0,0,0,0,0, 0,1,1,0,1,0,1},
    // E: core-only light sleep, bus and state mismatch ignored, timer wakes (R5 R4)
    '{1,0,0,0,1,1,0,0,0,0,0,0,0,1, 0,1,1,0,0,1,0},
    '{0,0,0,0,1,1,0,0,1,1,0,0,0,0, 0,1,1,0,0,1,0},
    '{0,0,0,0,1,1,1,0,0,0,0,0,0,0, 0,1,1,0,0,1,1},
    '{0,0,0,0,1,1,0,0,0,0,0,0,1,0, 0,1,1,0,0,1,1},
    '{0,0,0,0,1,1,0,0,0,0,0,0,0,0, 0,1,1,0,1,0,1}
  };

  function automatic string rowReq(int i);
    if (i < 10)      return "R2/R3/R6/R8/R9/R10/R11";
    else if (i < 16) return "R4/R7";
    else if (i < 22) return "R4/R6/R11";
    else if (i < 28) return "R5";
    else             return "R5/R4";
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic eq, logic em, logic eu, logic ec,
                       logic eg, logic es, logic ee);
    logic [NU+5:0] act, exp;
    act = {quiesce, memEnable, unitEnable, coreIrq, busGrant, sleepEn, wakeEvent};
    exp = {eq, em, {NU{eu}}, ec, eg, es, ee};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual qui/mem/units/irq/gnt/sle/evt=%b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    sleepReq      = v.sr;
    cfgSysMode    = v.sys;
    cfgMemLp      = v.mlp;
    cfgDeepCore   = v.dp;
    cfgHostMode   = v.hst;
    wakeIrqEn     = v.ien;
    coreTbReq     = v.tb;
    coreIrqReq    = v.irq;
    busReqPending = v.brq;
    pmNext        = v.pmx ? PW'(1) : '0;
    memReady      = v.mrd;
    unitReady     = v.urd ? '1 : '0;
    coreReady     = v.crd;
    evtClr        = v.clr;
  endtask

  task automatic idle();
    apply('0);
    wakeIrqEn = 1'b1;
  endtask

  initial begin
    pmCur = '0;
    idle();
    repeat (3) step();
    check("R1", 0, 1, 1, 0, 1, 0, 0);  // state while in reset
    rst_n = 1'b1;
    step();
    check("R1", 0, 1, 1, 0, 1, 0, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      step();
      check(rowReq(i), VECS[i].eq, VECS[i].em, VECS[i].eu, VECS[i].ec,
            VECS[i].eg, VECS[i].es, VECS[i].ee);
    end

    // R9: partial unit readiness in system mode holds the sequence.
    idle(); cfgSysMode = 1; cfgHostMode = 1; sleepReq = 1; step();
    idle(); coreIrqReq = 1; step();            // UNITS_ENABLE
    check("R8", 1, 1, 1, 1, 0, 1, 1);
    idle(); step();                            // WAIT_READY
    unitReady = 4'b1011; coreReady = 1; step();
    check("R9", 1, 1, 1, 0, 0, 1, 1);
    unitReady = '1; coreReady = 0; step();
    check("R9", 1, 1, 1, 0, 0, 1, 1);
    unitReady = '1; coreReady = 1; step();     // RELEASE
    check("R10", 0, 1, 1, 0, 0, 1, 1);
    idle(); step();
    check("R10", 0, 1, 1, 0, 1, 0, 1);

    // R1: reset in the middle of a sleep episode returns to full-on.
    idle(); cfgSysMode = 1; cfgMemLp = 1; sleepReq = 1; step();
    idle(); step();
    check("R2", 1, 0, 0, 0, 0, 1, 1);
    rst_n = 0; step();
    rst_n = 1; step();
    check("R1", 0, 1, 1, 0, 1, 0, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule